// File: doc/BRIEF.md
# Paged Audio Controller Host Register File

This block is the host-side register set of a three-channel audio DMA controller (two playback channels and one capture channel). A host reaches it through a 256-byte I/O window with byte, 16-bit and 32-bit reads and writes. It stores a global control word, a serial/format control word, a 16-bit codec word and a 4-bit page register. It also keeps an interrupt status word that the channel engines update. The channel data movers and the codec serial link sit outside the block. They read the control words and the per-channel frame registers through dedicated output ports, and they report a completed transfer by pulsing one bit per channel.

Offsets 0x30 to 0x3F form a small paged window. The effective address is the offset with the page value placed in bits 11:8. Page 0xC holds the frame address and frame count words of the two playback channels. Page 0xD holds the frame words of the capture channel, followed by two unused slots. Each channel has a pending interrupt flag, and the flag is set only when that channel's enable bit is on. All pending flags are merged into one interrupt output and into status bit 31.

Top module: `snd_host_regs`

## Requirements
- R1: After reset the registers read as follows: control 0x00000001, status 0x00000060, serial control 0, page 0 and codec 0. The interrupt output is low and `rd_valid` is low.
- R2: A byte write (`bus_size`=0) to offsets 0x00..0x03 (control) or 0x20..0x23 (serial control) replaces only byte lane `bus_addr[1:0]`, taking the byte from `bus_wdata[7:0]`.
- R3: A 16-bit write (`bus_size`=1) at +0 or +2 of control or serial control replaces only that half, taking the data from `bus_wdata[15:0]`. A 32-bit write (`bus_size`=2) replaces the whole word.
- R4: The page register at offset 0x0C stores only bits 3:0 of a byte or 32-bit write.
- R5: For offsets 0x30..0x3F the effective address is offset | (page << 8). The frame address and count words are at 0xC30/0xC34 (channel 0), 0xC38/0xC3C (channel 1) and 0xD30/0xD34 (channel 2). They are written with 32-bit accesses only. Every other page, and 0xD38/0xD3C, is unmapped.
- R6: A pulse on `chan_done[i]` sets pending flag i only while serial-control bit 8+i is 1. Pending flags read at status bit 2 (channel 0), bit 1 (channel 1) and bit 0 (channel 2). Status bit 31 and `irq_out` both equal the OR of the three flags.
- R7: A serial-control write that takes bit 8+i from 1 to 0 clears pending flag i. When a set and a clear occur in the same cycle, the clear wins.
- R8: Status bits 6:5 hold the index of the channel that most recently set a pending flag. When several channels set a flag together, the lowest index is recorded. The field resets to 3.
- R9: A read of an unmapped offset, or with a width that offset does not support, returns all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF). A byte read of offset 0x1B returns 5.
- R10: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after `bus_rd`, and `rd_valid` is low otherwise.
- R11: Writes to the status word at offset 0x04 have no effect.
- R12: The codec word at 0x10 is written by a 16-bit write and read as a 32-bit word that is zero above bit 15. A frame count word can also be read as 16-bit halves at +0 (bits 15:0) and +2 (bits 31:16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the I/O window |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 32 | Registered read data, right-justified |
| rd_valid | output | 1 | High the cycle after a read strobe |
| chan_done | input | 3 | Per-channel transfer-complete pulses |
| irq_out | output | 1 | OR of the pending flags |
| ctrl_o | output | 32 | Global control word to the channel block |
| sctrl_o | output | 32 | Serial/format control word to the channel block |
| frame_addr_o | output | 96 | Frame address words, channel 0 in bits 31:0 |
| frame_cnt_o | output | 96 | Frame count words, channel 0 in bits 31:0 |

## Verification
Control writes are tested with byte, half and word patterns in different lanes. Each pattern leaves a distinct value in the untouched lanes, so a lane that is decoded wrongly cannot hide. Paged accesses are made at the same offset with page 0, page 0xC and page 0xD, which separates correct redirection from a fixed decode. Completion pulses arrive with the enable off, with one channel alone, and with two channels together. These cases separate the gating, the priority of the source field and the clear-on-disable path. Unmapped reads cover all three widths, because the fill pattern depends on the width.

// File: rtl/snd_regs_pkg.sv
// Package: shared types, constants and helpers for the audio host registers.
// Assumes right-justified bus data and a 32-bit register width.
package snd_regs_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned NCH    = 3;
    localparam int unsigned PAGE_W = 4;
    localparam int unsigned OFF_W  = 8;
    localparam int unsigned EFF_W  = OFF_W + PAGE_W;
    localparam int unsigned CODEC_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_CTRL,
        RS_STAT,
        RS_PAGE,
        RS_CODEC,
        RS_SCTRL,
        RS_LEGACY,
        RS_FADDR,
        RS_FCNT
    } reg_sel_e;

    // All-ones pattern for the given access width.
    function automatic logic [DW-1:0] width_fill(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Replace only the lanes covered by an access of the given width.
    function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] wd,
                                                  input acc_size_e     sz,
                                                  input logic [1:0]    lane);
        logic [DW-1:0] m;
        logic [DW-1:0] d;
        case (sz)
            SZ_BYTE: begin
                m = 32'h0000_00FF << {lane, 3'b000};
                d = {24'b0, wd[7:0]} << {lane, 3'b000};
            end
            SZ_HALF: begin
                m = 32'h0000_FFFF << {lane[1], 4'b0000};
                d = {16'b0, wd[15:0]} << {lane[1], 4'b0000};
            end
            default: begin
                m = '1;
                d = wd;
            end
        endcase
        return (old_w & ~m) | (d & m);
    endfunction

endpackage

// File: rtl/snd_addr_map.sv
// Address decoder: applies the page redirect to offsets 0x30..0x3F and
// classifies the access into a register select with legal read/write flags.
// Assumes one access per cycle; purely combinational.
module snd_addr_map
    import snd_regs_pkg::*;
(
    input  logic [OFF_W-1:0]  bus_addr,
    input  acc_size_e         bus_size,
    input  logic [PAGE_W-1:0] page,
    output reg_sel_e          sel,
    output logic [1:0]        chan,
    output logic              rd_ok,
    output logic              wr_ok
);

    localparam logic [3:0] WIN_NIBBLE = 4'h3;

    logic [EFF_W-1:0] eff;
    logic [EFF_W-1:0] word_addr;
    logic             aligned;
    logic             is_b, is_h, is_w;

    // Build the effective address through the page window.
    always_comb begin
        if (bus_addr[OFF_W-1:4] == WIN_NIBBLE)
            eff = {page, bus_addr};
        else
            eff = {{PAGE_W{1'b0}}, bus_addr};
        word_addr = {eff[EFF_W-1:2], 2'b00};
    end

    // Width and alignment qualifiers.
    always_comb begin
        is_b = (bus_size == SZ_BYTE);
        is_h = (bus_size == SZ_HALF) && !eff[0];
        is_w = (bus_size == SZ_WORD) && (eff[1:0] == 2'b00);
        aligned = is_b || is_h || is_w;
    end

    // Register classification and per-width legality.
    always_comb begin
        sel   = RS_NONE;
        chan  = 2'd0;
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        case (word_addr)
            12'h000: begin sel = RS_CTRL;  rd_ok = is_b || is_w; wr_ok = aligned; end
            12'h004: begin sel = RS_STAT;  rd_ok = is_b || is_w; end
            12'h00C: begin
                sel   = RS_PAGE;
                rd_ok = (is_b && eff[1:0] == 2'b00) || is_w;
                wr_ok = (is_b && eff[1:0] == 2'b00) || is_w;
            end
            12'h010: begin sel = RS_CODEC; rd_ok = is_w; wr_ok = is_h && !eff[1]; end
            12'h018: begin sel = RS_LEGACY; rd_ok = is_b && (eff[1:0] == 2'b11); end
            12'h020: begin sel = RS_SCTRL; rd_ok = is_w; wr_ok = aligned; end
            12'hC30: begin sel = RS_FADDR; chan = 2'd0; rd_ok = is_w; wr_ok = is_w; end
            12'hC38: begin sel = RS_FADDR; chan = 2'd1; rd_ok = is_w; wr_ok = is_w; end
            12'hD30: begin sel = RS_FADDR; chan = 2'd2; rd_ok = is_w; wr_ok = is_w; end
            12'hC34: begin sel = RS_FCNT;  chan = 2'd0; rd_ok = is_w || is_h; wr_ok = is_w; end
            12'hC3C: begin sel = RS_FCNT;  chan = 2'd1; rd_ok = is_w || is_h; wr_ok = is_w; end
            12'hD34: begin sel = RS_FCNT;  chan = 2'd2; rd_ok = is_w || is_h; wr_ok = is_w; end
            default: ;
        endcase
    end

endmodule

// File: rtl/snd_irq_status.sv
// Pending-flag tracker: sets a channel flag on a done pulse while its enable
// is on, clears it when software drops the enable, and records the source.
// Assumes en_fall is a single-cycle mask derived from a control write.
module snd_irq_status
    import snd_regs_pkg::*;
#(
    parameter logic [1:0] SRC_RESET = 2'd3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] en_fall,
    output logic [NCH-1:0] pend,
    output logic [1:0]     src
);

    logic [NCH-1:0] set_v;
    logic [1:0]     src_next;

    // Gate done pulses by enable and pick the lowest-index setter.
    always_comb begin
        set_v    = done & en;
        src_next = src;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (set_v[i]) src_next = 2'(i);
        end
    end

    // Pending flags and source field; a clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            src  <= SRC_RESET;
        end else begin
            pend <= (pend | set_v) & ~en_fall;
            src  <= src_next;
        end
    end

endmodule

// File: rtl/snd_frame_bank.sv
// Per-channel frame address and frame count words, one pair per channel.
// Assumes the write strobes are already decoded and one-hot.
module snd_frame_bank
    import snd_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    wr_addr,
    input  logic [NCH-1:0]    wr_cnt,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*DW-1:0] faddr,
    output logic [NCH*DW-1:0] fcnt
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] addr_q;
        logic [DW-1:0] cnt_q;

        // Hold the channel's frame words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                cnt_q  <= '0;
            end else begin
                if (wr_addr[g]) addr_q <= wdata;
                if (wr_cnt[g])  cnt_q  <= wdata;
            end
        end

        assign faddr[g*DW +: DW] = addr_q;
        assign fcnt[g*DW +: DW]  = cnt_q;
    end

endmodule

// File: rtl/snd_host_regs.sv
// Top of the audio host register file: control, serial control, page and
// codec words, the status word with merged interrupt, and a registered read
// path. Assumes bus_rd and bus_wr are never high in the same cycle.
module snd_host_regs
    import snd_regs_pkg::*;
#(
    parameter logic [DW-1:0] CTRL_RESET = 32'h0000_0001,
    parameter logic [7:0]    LEGACY_VAL = 8'h05,
    parameter int unsigned   EN_BASE    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic [2:0]        chan_done,
    output logic              irq_out,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       sctrl_o,
    output logic [95:0]       frame_addr_o,
    output logic [95:0]       frame_cnt_o
);

    acc_size_e           size_e;
    reg_sel_e            sel;
    logic [1:0]          chan;
    logic                rd_ok, wr_ok, wr_go;
    logic [DW-1:0]       ctrl_q, sctrl_q, sctrl_next;
    logic [PAGE_W-1:0]   page_q;
    logic [CODEC_W-1:0]  codec_q;
    logic [NCH-1:0]      pend_vec, en_vec, en_fall;
    logic [1:0]          src;
    logic [DW-1:0]       stat_w;
    logic [NCH-1:0]      wr_faddr, wr_fcnt;
    logic [DW-1:0]       raw, rd_next;

    assign size_e = acc_size_e'(bus_size);
    assign wr_go  = bus_wr && wr_ok;

    snd_addr_map u_map (
        .bus_addr (bus_addr),
        .bus_size (size_e),
        .page     (page_q),
        .sel      (sel),
        .chan     (chan),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );

    // Next serial-control value and the enables it would drop.
    always_comb begin
        sctrl_next = merge_lanes(sctrl_q, bus_wdata, size_e, bus_addr[1:0]);
        en_vec     = sctrl_q[EN_BASE +: NCH];
        en_fall    = '0;
        if (wr_go && sel == RS_SCTRL)
            en_fall = en_vec & ~sctrl_next[EN_BASE +: NCH];
    end

    // Host-written configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            sctrl_q <= '0;
            page_q  <= '0;
            codec_q <= '0;
        end else if (wr_go) begin
            case (sel)
                RS_CTRL:  ctrl_q  <= merge_lanes(ctrl_q, bus_wdata, size_e, bus_addr[1:0]);
                RS_SCTRL: sctrl_q <= sctrl_next;
                RS_PAGE:  page_q  <= bus_wdata[PAGE_W-1:0];
                RS_CODEC: codec_q <= bus_wdata[CODEC_W-1:0];
                default:  ;
            endcase
        end
    end

    snd_irq_status u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (chan_done),
        .en      (en_vec),
        .en_fall (en_fall),
        .pend    (pend_vec),
        .src     (src)
    );

    // Decode one-hot frame-word write strobes.
    always_comb begin
        wr_faddr = '0;
        wr_fcnt  = '0;
        if (wr_go && sel == RS_FADDR) wr_faddr[chan] = 1'b1;
        if (wr_go && sel == RS_FCNT)  wr_fcnt[chan]  = 1'b1;
    end

    snd_frame_bank u_frames (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (wr_faddr),
        .wr_cnt  (wr_fcnt),
        .wdata   (bus_wdata),
        .faddr   (frame_addr_o),
        .fcnt    (frame_cnt_o)
    );

    // Status word: summary bit, source field, flags in channel-reversed order.
    assign stat_w = {|pend_vec, 24'b0, src, 2'b00, pend_vec[0], pend_vec[1], pend_vec[2]};

    // Read multiplexer with lane shift and width fill.
    always_comb begin
        case (sel)
            RS_CTRL:  raw = ctrl_q;
            RS_STAT:  raw = stat_w;
            RS_PAGE:  raw = {{(DW-PAGE_W){1'b0}}, page_q};
            RS_CODEC: raw = {{(DW-CODEC_W){1'b0}}, codec_q};
            RS_SCTRL: raw = sctrl_q;
            RS_FADDR: raw = frame_addr_o[chan*DW +: DW];
            RS_FCNT:  raw = frame_cnt_o[chan*DW +: DW];
            default:  raw = '0;
        endcase
        if (!rd_ok)
            rd_next = width_fill(size_e);
        else if (sel == RS_LEGACY)
            rd_next = {24'b0, LEGACY_VAL};
        else
            rd_next = (raw >> {bus_addr[1:0], 3'b000}) & width_fill(size_e);
    end

    // Registered read return, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd) rd_data <= rd_next;
        end
    end

    assign irq_out = |pend_vec;
    assign ctrl_o  = ctrl_q;
    assign sctrl_o = sctrl_q;

endmodule

// File: rtl/snd_host_regs_chk.sv
// Checker for snd_host_regs: temporal properties on the read handshake and
// the pending-flag rules. Attached to the top with a bind statement below.
module snd_host_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [2:0]  chan_done,
    input logic [31:0] sctrl,
    input logic [2:0]  pend,
    input logic        rd_valid
);

    a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid);

    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r6_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_done[0] && !sctrl[8] && !pend[0]) |=> !pend[0]);

    a_r6_set_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $past(chan_done[1]));

    a_r7_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sctrl[10]) |-> !pend[2]);

endmodule

bind snd_host_regs snd_host_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .chan_done (chan_done),
    .sctrl     (sctrl_o),
    .pend      (pend_vec),
    .rd_valid  (rd_valid)
);

// File: tb/snd_host_regs_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read data, a monitor pops
// and compares each returned word on the falling edge.
module snd_host_regs_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        bus_wr, bus_rd;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [2:0]  chan_done;
    logic        irq_out;
    logic [31:0] ctrl_o, sctrl_o;
    logic [95:0] frame_addr_o, frame_cnt_o;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    snd_host_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .chan_done    (chan_done),
        .irq_out      (irq_out),
        .ctrl_o       (ctrl_o),
        .sctrl_o      (sctrl_o),
        .frame_addr_o (frame_addr_o),
        .frame_cnt_o  (frame_cnt_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s,
                      input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        chan_done = m;
        @(negedge clk);
        chan_done = 3'b000;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: compare each returned read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
        bus_wr = 1'b0; bus_rd = 1'b0; chan_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(irq_out === 1'b0, "R1", {31'b0, irq_out}, 32'h0);
        check(rd_valid === 1'b0, "R1", {31'b0, rd_valid}, 32'h0);
        rd(8'h00, 2'd2, 32'h0000_0001, "R1");
        rd(8'h04, 2'd2, 32'h0000_0060, "R1 R8");
        rd(8'h0C, 2'd2, 32'h0, "R1");
        rd(8'h10, 2'd2, 32'h0, "R1");
        rd(8'h20, 2'd2, 32'h0, "R1");

        // R2: byte lane replacement
        wr(8'h02, 2'd0, 32'hFFFF_FFAB);
        rd(8'h00, 2'd2, 32'h00AB_0001, "R2");
        rd(8'h02, 2'd0, 32'h0000_00AB, "R2");
        // R3: half and word replacement
        wr(8'h00, 2'd1, 32'h5555_1234);
        rd(8'h00, 2'd2, 32'h00AB_1234, "R3");
        wr(8'h02, 2'd1, 32'h0000_CAFE);
        rd(8'h00, 2'd2, 32'hCAFE_1234, "R3");
        check(ctrl_o === 32'hCAFE_1234, "R3", ctrl_o, 32'hCAFE_1234);
        wr(8'h20, 2'd2, 32'h0000_0000);

        // R4: page keeps bits 3:0
        wr(8'h0C, 2'd2, 32'hFFFF_FFF7);
        rd(8'h0C, 2'd2, 32'h0000_0007, "R4");
        rd(8'h0C, 2'd0, 32'h0000_0007, "R4");

        // R5 / R12: paged frame registers
        wr(8'h0C, 2'd2, 32'h0000_000C);
        wr(8'h30, 2'd2, 32'h1111_1111);
        wr(8'h34, 2'd2, 32'h2222_3333);
        wr(8'h38, 2'd2, 32'h4444_4444);
        wr(8'h0C, 2'd2, 32'h0000_000D);
        wr(8'h30, 2'd2, 32'h5555_5555);
        wr(8'h38, 2'd2, 32'h6666_6666);
        rd(8'h30, 2'd2, 32'h5555_5555, "R5");
        rd(8'h38, 2'd2, 32'hFFFF_FFFF, "R5");
        wr(8'h0C, 2'd2, 32'h0000_000C);
        rd(8'h30, 2'd2, 32'h1111_1111, "R5");
        rd(8'h38, 2'd2, 32'h4444_4444, "R5");
        rd(8'h36, 2'd1, 32'h0000_2222, "R12");
        rd(8'h34, 2'd1, 32'h0000_3333, "R12");
        check(frame_addr_o[31:0] === 32'h1111_1111, "R5", frame_addr_o[31:0], 32'h1111_1111);
        check(frame_addr_o[95:64] === 32'h5555_5555, "R5", frame_addr_o[95:64], 32'h5555_5555);
        wr(8'h0C, 2'd2, 32'h0000_0000);
        rd(8'h30, 2'd2, 32'hFFFF_FFFF, "R5");

        // R9: unmapped fill per width and the legacy byte
        rd(8'h1B, 2'd0, 32'h0000_0005, "R9");
        rd(8'h40, 2'd0, 32'h0000_00FF, "R9");
        rd(8'h44, 2'd1, 32'h0000_FFFF, "R9");
        rd(8'h48, 2'd2, 32'hFFFF_FFFF, "R9");
        rd(8'h10, 2'd0, 32'h0000_00FF, "R9");

        // R12: codec word
        wr(8'h10, 2'd1, 32'h1234_BEEF);
        rd(8'h10, 2'd2, 32'h0000_BEEF, "R12");

        // R11: status is read-only
        wr(8'h04, 2'd2, 32'hFFFF_FFFF);
        rd(8'h04, 2'd2, 32'h0000_0060, "R11");

        // R6: pulse with enable off is ignored
        pulse(3'b001);
        rd(8'h04, 2'd2, 32'h0000_0060, "R6");
        check(irq_out === 1'b0, "R6", {31'b0, irq_out}, 32'h0);
        // enable all three channels (bits 10:8)
        wr(8'h21, 2'd0, 32'h0000_0007);
        pulse(3'b100);
        check(irq_out === 1'b1, "R6", {31'b0, irq_out}, 32'h1);
        rd(8'h04, 2'd2, 32'h8000_0041, "R6 R8");
        // R8: two channels together, lowest index recorded
        pulse(3'b011);
        rd(8'h04, 2'd2, 32'h8000_0007, "R8");

        // R7: dropping an enable clears that flag only
        wr(8'h21, 2'd0, 32'h0000_0006);
        rd(8'h04, 2'd2, 32'h8000_0003, "R7");
        wr(8'h21, 2'd0, 32'h0000_0000);
        rd(8'h04, 2'd2, 32'h0000_0000, "R7");
        check(irq_out === 1'b0, "R7", {31'b0, irq_out}, 32'h0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", exp_q.size(), 32'h0);
        summary();
        $finish;
    end

endmodule